// File: doc/BRIEF.md
# Coin Credit Vending Controller

This block is a small synchronous state machine that sits behind a single coin slot. Every clock cycle it may receive a coin strobe together with a code saying what kind of coin was sensed. Five-cent and ten-cent coins add to a running credit. Once the credit reaches fifteen cents or more, the block issues a one-cycle release pulse for a single item and starts again from zero. A coin whose code is not recognized is handed back through a one-cycle return pulse and adds nothing to the credit.

The credit is held in three named states: `CR0` (nothing paid), `CR5` (five cents paid) and `CR10` (ten cents paid). The transitions are: `CR0 --nickel--> CR5`, `CR0 --dime--> CR10`, `CR5 --nickel--> CR10`, `CR5 --dime--> CR0` with release (fifteen cents), `CR10 --nickel--> CR0` with release (fifteen cents), `CR10 --dime--> CR0` with release (twenty cents, the extra five cents is kept and not paid back). A strobe with an unknown code, or a cycle without a strobe, leaves the state where it is. Both output pulses are registered, so they appear in the cycle after the strobe that caused them.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the credit returns to `CR0`, and `vend_out` and `coin_back` are both low in the cycle after that edge.
- R2: A strobe with `coin_kind` = 2'b01 (five cents) moves `CR0` to `CR5` and `CR5` to `CR10`, with no release pulse.
- R3: A strobe with `coin_kind` = 2'b10 (ten cents) moves `CR0` to `CR10`, and from `CR5` it completes fifteen cents.
- R4: When a coin brings the credit to fifteen or more (`CR5` plus ten, `CR10` plus five, `CR10` plus ten), `vend_out` is high for exactly the cycle after that strobe, and the state becomes `CR0`.
- R5: Credit beyond fifteen cents is discarded: after a ten-cent coin in `CR10`, a single following ten-cent coin does not release an item.
- R6: A strobe with `coin_kind` = 2'b00 or 2'b11 raises `coin_back` for exactly the cycle after that strobe and leaves the credit unchanged.
- R7: A cycle with `coin_valid` low leaves the credit unchanged and produces no pulse in the next cycle.
- R8: `vend_out` and `coin_back` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coin_valid | input | 1 | One coin is present in this cycle |
| coin_kind | input | 2 | Coin code: 01 five cents, 10 ten cents, 00 and 11 unknown |
| vend_out | output | 1 | One-cycle pulse releasing one item |
| coin_back | output | 1 | One-cycle pulse returning an unknown coin |

## Verification
On every cycle the embedded assertions check that the two pulses never overlap, that an unknown coin is always followed by a return pulse with the credit held, that an idle cycle holds the state, that a completing coin always lands in `CR0` with a release pulse, and that reset clears both outputs. Whether the credit is actually accumulated in the right amounts over a sequence of coins, that surplus credit is dropped rather than carried over, and that unknown codes interleaved between valid coins do not disturb the count can only be shown by the bench's coin sequences, which a reference credit model compares pulse by pulse.

// File: rtl/vend_pkg.sv
package vend_pkg;

    // Credit held by the controller
    typedef enum logic [1:0] {
        CR0  = 2'd0,
        CR5  = 2'd1,
        CR10 = 2'd2
    } credit_t;

    // Classified coin event for one cycle
    typedef enum logic [1:0] {
        COIN_NONE   = 2'd0,
        COIN_NICKEL = 2'd1,
        COIN_DIME   = 2'd2,
        COIN_BAD    = 2'd3
    } coin_class_t;

endpackage

// File: rtl/vend_coin_classify.sv
module vend_coin_classify
    import vend_pkg::*;
#(
    parameter int KIND_W = 2,
    parameter logic [KIND_W-1:0] NICKEL_CODE = 'd1,
    parameter logic [KIND_W-1:0] DIME_CODE   = 'd2
) (
    input  logic              coin_valid,
    input  logic [KIND_W-1:0] coin_kind,
    output coin_class_t       coin_cls
);

    always_comb begin
        if (!coin_valid)
            coin_cls = COIN_NONE;
        else if (coin_kind == NICKEL_CODE)
            coin_cls = COIN_NICKEL;
        else if (coin_kind == DIME_CODE)
            coin_cls = COIN_DIME;
        else
            coin_cls = COIN_BAD;
    end

endmodule

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm
    import vend_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  coin_class_t coin_cls,
    output logic        vend_out,
    output logic        coin_back
);

    credit_t state, state_nxt;
    logic    vend_nxt, back_nxt;

    // Next-state and next-output decision
    always_comb begin
        state_nxt = state;
        vend_nxt  = 1'b0;
        back_nxt  = 1'b0;
        unique case (coin_cls)
            COIN_NONE: ;
            COIN_BAD:  back_nxt = 1'b1;
            COIN_NICKEL: begin
                unique case (state)
                    CR0:  state_nxt = CR5;
                    CR5:  state_nxt = CR10;
                    CR10: begin
                        state_nxt = CR0;
                        vend_nxt  = 1'b1;
                    end
                    default: state_nxt = CR0;
                endcase
            end
            COIN_DIME: begin
                unique case (state)
                    CR0: state_nxt = CR10;
                    CR5, CR10: begin
                        state_nxt = CR0;
                        vend_nxt  = 1'b1;
                    end
                    default: state_nxt = CR0;
                endcase
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state <= CR0;
        else
            state <= state_nxt;
    end

    // Registered output pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            vend_out  <= 1'b0;
            coin_back <= 1'b0;
        end else begin
            vend_out  <= vend_nxt;
            coin_back <= back_nxt;
        end
    end

    // R1: reset clears both pulses
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!vend_out && !coin_back));

    // R6: an unknown coin is returned and the credit holds
    a_r6_bad_returned: assert property (@(posedge clk) disable iff (rst)
        (coin_cls == COIN_BAD) |=> (coin_back && $stable(state)));

    // R7: idle cycle holds the credit and gives no pulse
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (coin_cls == COIN_NONE) |=> ($stable(state) && !vend_out && !coin_back));

    // R4: completing coin releases one item and returns to zero credit
    a_r4_release_to_zero: assert property (@(posedge clk) disable iff (rst)
        ((state == CR10 && coin_cls != COIN_NONE && coin_cls != COIN_BAD) ||
         (state == CR5 && coin_cls == COIN_DIME))
        |=> (vend_out && state == CR0));

    // R4: a release pulse lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        vend_out |=> !vend_out);

    // R8: the two pulses are exclusive
    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(vend_out && coin_back));

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int KIND_W = 2,
    parameter logic [KIND_W-1:0] NICKEL_CODE = 'd1,
    parameter logic [KIND_W-1:0] DIME_CODE   = 'd2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              coin_valid,
    input  logic [KIND_W-1:0] coin_kind,
    output logic              vend_out,
    output logic              coin_back
);

    coin_class_t coin_cls;

    vend_coin_classify #(
        .KIND_W      (KIND_W),
        .NICKEL_CODE (NICKEL_CODE),
        .DIME_CODE   (DIME_CODE)
    ) u_classify (
        .coin_valid (coin_valid),
        .coin_kind  (coin_kind),
        .coin_cls   (coin_cls)
    );

    vend_credit_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .coin_cls  (coin_cls),
        .vend_out  (vend_out),
        .coin_back (coin_back)
    );

endmodule

// File: tb/tb_vend_ctrl.sv
module tb_vend_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       coin_valid = 1'b0;
    logic [1:0] coin_kind = 2'b00;
    logic       vend_out;
    logic       coin_back;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    typedef struct {
        bit    vend;
        bit    back;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   model_credit = 0;

    always #10 clk = ~clk;

    vend_ctrl dut (
        .clk        (clk),
        .rst        (rst),
        .coin_valid (coin_valid),
        .coin_kind  (coin_kind),
        .vend_out   (vend_out),
        .coin_back  (coin_back)
    );

    // Driver: applies one cycle of stimulus and pushes the expected pulses
    task automatic step(input bit r, input bit v, input logic [1:0] k, input string tag);
        exp_t e;
        @(negedge clk);
        rst        = r;
        coin_valid = v;
        coin_kind  = k;
        e.vend = 1'b0;
        e.back = 1'b0;
        e.tag  = tag;
        if (r) begin
            model_credit = 0;
        end else if (v) begin
            if (k == 2'b01)      model_credit += 5;
            else if (k == 2'b10) model_credit += 10;
            else                 e.back = 1'b1;
            if (model_credit >= 15) begin
                e.vend = 1'b1;
                model_credit = 0;
            end
        end
        exp_q.push_back(e);
    endtask

    // Monitor: after each rising edge, compare with the oldest expectation
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (vend_out !== e.vend) begin
                failures++;
                $display("FAIL %s vend_out actual=%0b expected=%0b", e.tag, vend_out, e.vend);
            end
            checks++;
            if (coin_back !== e.back) begin
                failures++;
                $display("FAIL %s coin_back actual=%0b expected=%0b", e.tag, coin_back, e.back);
            end
            checks++;
            if (vend_out && coin_back) begin
                failures++;
                $display("FAIL R8 overlap actual=11 expected=not both");
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset with coins offered, outputs stay low
        step(1, 1, 2'b10, "R1");
        step(1, 1, 2'b10, "R1");
        step(1, 0, 2'b00, "R1");
        // R7: idle cycles
        step(0, 0, 2'b10, "R7");
        step(0, 0, 2'b01, "R7");
        // R2 with idles between: three nickels
        step(0, 1, 2'b01, "R2");
        step(0, 0, 2'b00, "R7");
        step(0, 1, 2'b01, "R2");
        step(0, 0, 2'b00, "R7");
        step(0, 0, 2'b00, "R7");
        step(0, 1, 2'b01, "R4");
        // R3: dime then nickel, nickel then dime
        step(0, 1, 2'b10, "R3");
        step(0, 1, 2'b01, "R4");
        step(0, 1, 2'b01, "R3");
        step(0, 1, 2'b10, "R4");
        // R5: two dimes, then surplus is gone
        step(0, 1, 2'b10, "R5");
        step(0, 1, 2'b10, "R5");
        step(0, 1, 2'b10, "R5");
        step(0, 1, 2'b01, "R5");
        // R6: unknown codes between nickels
        step(0, 1, 2'b00, "R6");
        step(0, 1, 2'b01, "R6");
        step(0, 1, 2'b11, "R6");
        step(0, 1, 2'b01, "R6");
        step(0, 1, 2'b00, "R6");
        step(0, 1, 2'b11, "R6");
        step(0, 1, 2'b01, "R6");
        // R4: back-to-back dimes and nickels in a long run
        for (int i = 0; i < 12; i++) begin
            step(0, 1, (i % 3 == 0) ? 2'b01 : 2'b10, "R4");
        end
        // R1: reset in the middle of a credit
        step(0, 1, 2'b10, "R1");
        step(1, 0, 2'b00, "R1");
        step(0, 1, 2'b01, "R1");
        step(0, 1, 2'b01, "R1");
        step(0, 0, 2'b00, "R7");
        step(0, 1, 2'b01, "R4");
        step(0, 0, 2'b00, "R7");
        step(0, 0, 2'b00, "R7");
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule